// File: doc/BRIEF.md
# Descriptor-Driven Endpoint Buffer Mover

The block moves one packet between a packet engine and a buffer in a shared byte-wide RAM. A start strobe supplies a descriptor index and a direction. The block reads a four-byte descriptor from a table at a fixed base address. From that descriptor it takes a status byte, a count, and a 16-bit buffer start address. It then streams bytes. In the transmit direction it reads them from the buffer and presents them on a valid/ready output stream. In the receive direction it accepts them from a valid/ready input stream and writes them into the buffer.

When the packet ends, the block writes the number of bytes actually moved back into the descriptor's count fields. It then pulses a done strobe that carries the same count and an overflow flag. A freeze flag in the status byte pins every data access to the buffer start address, so that a streaming port can sit behind a single location. The block issues at most one RAM access per cycle. Its RAM read data arrives one cycle after the read request.

Top module: `bdesc_mover`

## Requirements
- R1: After reset, busy_o, done_o, ram_req_o, ram_we_o, rx_ready_o and tx_valid_o are all 0.
- R2: Descriptor n occupies four bytes starting at 400h + 4n. The byte at offset 0 is the status byte, offset 1 is the count low byte, offset 2 is the address low byte and offset 3 is the address high byte. The buffer start address is {address high, address low}.
- R3: The 10-bit count is {status[1:0], count low}. A transmit presents exactly that many bytes on tx_data_o, read from the buffer. tx_data_o is held stable while tx_valid_o waits for tx_ready_i. tx_last_o is 1 on the final byte only.
- R4: A receive writes accepted bytes to successive buffer addresses, starting at the buffer start address, up to the count. It ends when the byte flagged with rx_last_i is accepted.
- R5: In a receive, bytes beyond the count are still accepted but are not written. In that case done_ovf_o is 1 and the reported count equals the programmed count. done_ovf_o is 0 in every other case.
- R6: When status bit 4 is 1, every data read or write uses the buffer start address. When it is 0, the address advances by one per byte.
- R7: On completion, the moved count is written back. Its bits 7:0 go to descriptor offset 1. Its bits 9:8 go to status bits 1:0, with status bits 7:2 preserved. Offsets 2 and 3 are never written.
- R8: busy_o is 1 from the cycle after an accepted start through the cycle of done_o. done_o is a single-cycle pulse carrying done_count_o and done_ovf_o. busy_o is 0 in the following cycle.
- R9: A start strobe while busy_o is 1 is ignored. It leaves the running transfer, the other descriptor and the number of done pulses unaffected.
- R10: The block makes at most one RAM access per cycle. ram_we_o is 1 only together with ram_req_o, and no access is made while busy_o is 0.
- R11: A transmit with a count of 0 presents no bytes and writes back a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| start_i | input | 1 | Start strobe, sampled while idle |
| start_idx_i | input | 6 | Descriptor index |
| start_dir_i | input | 1 | 0 = receive into buffer, 1 = transmit from buffer |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| done_count_o | output | 10 | Bytes moved, valid with done_o |
| done_ovf_o | output | 1 | Receive overflow, valid with done_o |
| ram_req_o | output | 1 | RAM access request |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | 16 | RAM byte address |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data, one cycle after the read request |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_data_i | input | 8 | Receive byte |
| rx_last_i | input | 1 | Receive byte is the last of the packet |
| rx_ready_o | output | 1 | Block accepts a receive byte |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_data_o | output | 8 | Transmit byte |
| tx_last_o | output | 1 | Transmit byte is the last of the packet |
| tx_ready_i | input | 1 | Packet engine accepts the transmit byte |

## Verification
The hardest situation to reach is a receive overflow combined with the frozen address. Several bytes must arrive after the count is exhausted, and the bench must show that none of them reached RAM, not even at the single pinned location. The stimulus sweeps counts 0 to 3 against packet lengths from 1 up to count + 2, with the freeze flag both off and on, for descriptor indices at both ends of the table. In one case per group, a second start naming a neighbouring descriptor is fired while the fetch is still running. Transmit runs use a stalling ready pattern, so that the hold-while-waiting behaviour is exercised.

// File: rtl/bdm_pkg.sv
package bdm_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_F0, S_F1, S_F2, S_F3, S_F4,
    S_RX, S_TX_RD, S_TX_CAP, S_TX_SEND,
    S_WB_CNT, S_WB_STAT, S_DONE
  } bdm_state_e;

  typedef enum logic [1:0] {
    WSEL_RXDATA, WSEL_CNTLO, WSEL_STATUS
  } bdm_wsel_e;

  localparam int unsigned DESC_BYTES      = 4;
  localparam int unsigned DESC_KEPT       = DESC_BYTES - 1;
  localparam int unsigned OFF_STATUS      = 0;
  localparam int unsigned OFF_CNTLO       = 1;
  localparam int unsigned OFF_ADRLO       = 2;
  localparam int unsigned OFF_ADRHI       = 3;
  localparam int unsigned STAT_FREEZE_BIT = 4;
  localparam logic        DIR_RX          = 1'b0;
  localparam logic        DIR_TX          = 1'b1;
endpackage

// File: rtl/bdm_desc_regs.sv
module bdm_desc_regs #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NREG   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NREG-1:0]            cap_i,
  input  logic [BYTE_W-1:0]          byte_i,
  output logic [NREG-1:0][BYTE_W-1:0] regs_o
);
  logic [NREG-1:0][BYTE_W-1:0] regs_q;
  logic [NREG-1:0][BYTE_W-1:0] regs_d;

  for (genvar g = 0; g < NREG; g++) begin : g_byte
    always_comb begin
      regs_d[g] = regs_q[g];
      if (cap_i[g]) regs_d[g] = byte_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[g] <= '0;
      else        regs_q[g] <= regs_d[g];
    end
  end

  assign regs_o = regs_q;

  // R2: descriptor bytes are captured one per cycle, never two at once
  a_r2_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cap_i));
endmodule

// File: rtl/bdm_ptr.sv
module bdm_ptr #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  limit_i,
  input  logic              freeze_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              at_limit_o
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, limit_q, limit_d;
  logic              freeze_q, freeze_d;

  always_comb begin
    addr_d   = addr_q;
    cnt_d    = cnt_q;
    limit_d  = limit_q;
    freeze_d = freeze_q;
    if (load_i) begin
      addr_d   = base_i;
      cnt_d    = '0;
      limit_d  = limit_i;
      freeze_d = freeze_i;
    end else if (step_i) begin
      cnt_d = cnt_q + 1'b1;
      if (!freeze_q) addr_d = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      cnt_q    <= '0;
      limit_q  <= '0;
      freeze_q <= 1'b0;
    end else begin
      addr_q   <= addr_d;
      cnt_q    <= cnt_d;
      limit_q  <= limit_d;
      freeze_q <= freeze_d;
    end
  end

  assign addr_o     = addr_q;
  assign cnt_o      = cnt_q;
  assign at_limit_o = (cnt_q == limit_q);

  // R6: a frozen pointer does not move when a byte is moved
  a_r6_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && freeze_q) |=> $stable(addr_q));

  // R4: the controller never steps past the programmed count
  a_r4_cnt_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit_q);
endmodule

// File: rtl/bdm_ctrl.sv
module bdm_ctrl
  import bdm_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic                 dir_i,
  input  logic                 rx_valid_i,
  input  logic                 rx_last_i,
  input  logic                 tx_ready_i,
  input  logic                 at_limit_i,
  input  logic                 limit_zero_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic                 ovf_o,
  output logic [DESC_KEPT-1:0] cap_o,
  output logic                 ptr_load_o,
  output logic                 ptr_step_o,
  output logic                 ram_req_o,
  output logic                 ram_we_o,
  output logic                 use_buf_o,
  output logic [1:0]           tbl_off_o,
  output bdm_wsel_e            wsel_o,
  output logic                 rx_ready_o,
  output logic                 tx_cap_o,
  output logic                 tx_valid_o,
  output logic                 tx_last_o
);
  bdm_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             dir_q, dir_d;
  logic             ovf_q, ovf_d;

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    dir_d      = dir_q;
    ovf_d      = ovf_q;
    cap_o      = '0;
    ptr_load_o = 1'b0;
    ptr_step_o = 1'b0;
    ram_req_o  = 1'b0;
    ram_we_o   = 1'b0;
    use_buf_o  = 1'b0;
    tbl_off_o  = 2'd0;
    wsel_o     = WSEL_RXDATA;
    rx_ready_o = 1'b0;
    tx_cap_o   = 1'b0;
    tx_valid_o = 1'b0;
    done_o     = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        state_d = S_F0;
        idx_d   = idx_i;
        dir_d   = dir_i;
        ovf_d   = 1'b0;
      end
      S_F0: begin
        ram_req_o = 1'b1; tbl_off_o = 2'(OFF_STATUS); state_d = S_F1;
      end
      S_F1: begin
        ram_req_o = 1'b1; tbl_off_o = 2'(OFF_CNTLO);
        cap_o[OFF_STATUS] = 1'b1; state_d = S_F2;
      end
      S_F2: begin
        ram_req_o = 1'b1; tbl_off_o = 2'(OFF_ADRLO);
        cap_o[OFF_CNTLO] = 1'b1; state_d = S_F3;
      end
      S_F3: begin
        ram_req_o = 1'b1; tbl_off_o = 2'(OFF_ADRHI);
        cap_o[OFF_ADRLO] = 1'b1; state_d = S_F4;
      end
      S_F4: begin
        ptr_load_o = 1'b1;
        if (dir_q == DIR_RX)   state_d = S_RX;
        else if (limit_zero_i) state_d = S_WB_CNT;
        else                   state_d = S_TX_RD;
      end
      S_RX: begin
        rx_ready_o = 1'b1;
        if (rx_valid_i) begin
          if (!at_limit_i) begin
            ram_req_o  = 1'b1;
            ram_we_o   = 1'b1;
            use_buf_o  = 1'b1;
            ptr_step_o = 1'b1;
          end else begin
            ovf_d = 1'b1;
          end
          if (rx_last_i) state_d = S_WB_CNT;
        end
      end
      S_TX_RD: begin
        ram_req_o = 1'b1; use_buf_o = 1'b1; state_d = S_TX_CAP;
      end
      S_TX_CAP: begin
        tx_cap_o = 1'b1; ptr_step_o = 1'b1; state_d = S_TX_SEND;
      end
      S_TX_SEND: begin
        tx_valid_o = 1'b1;
        if (tx_ready_i) state_d = at_limit_i ? S_WB_CNT : S_TX_RD;
      end
      S_WB_CNT: begin
        ram_req_o = 1'b1; ram_we_o = 1'b1; tbl_off_o = 2'(OFF_CNTLO);
        wsel_o = WSEL_CNTLO; state_d = S_WB_STAT;
      end
      S_WB_STAT: begin
        ram_req_o = 1'b1; ram_we_o = 1'b1; tbl_off_o = 2'(OFF_STATUS);
        wsel_o = WSEL_STATUS; state_d = S_DONE;
      end
      S_DONE: begin
        done_o = 1'b1; state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      dir_q   <= DIR_RX;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      dir_q   <= dir_d;
      ovf_q   <= ovf_d;
    end
  end

  assign busy_o    = (state_q != S_IDLE);
  assign idx_o     = idx_q;
  assign ovf_o     = ovf_q;
  assign tx_last_o = tx_valid_o && at_limit_i;

  // R8: done is a single pulse followed by idle
  a_r8_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  // R9: a start while busy does not restart the fetch
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && start_i) |=> (state_q != S_F0));

  // R5: transmit transfers never report overflow
  a_r5_no_tx_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && dir_q == DIR_TX) |-> !ovf_q);

  // R10: no RAM traffic while idle, writes only with a request
  a_r10_ram_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o |-> !ram_req_o) and (ram_we_o |-> ram_req_o));
endmodule

// File: rtl/bdesc_mover.sv
module bdesc_mover
  import bdm_pkg::*;
#(
  parameter int unsigned IDX_W      = 6,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned CNT_W      = 10,
  parameter int unsigned BYTE_W     = 8,
  parameter logic [15:0] TABLE_BASE = 16'h0400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  start_idx_i,
  input  logic              start_dir_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  done_count_o,
  output logic              done_ovf_o,
  output logic              ram_req_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [BYTE_W-1:0] ram_wdata_o,
  input  logic [BYTE_W-1:0] ram_rdata_i,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              rx_last_i,
  output logic              rx_ready_o,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              tx_last_o,
  input  logic              tx_ready_i
);
  localparam int unsigned CNT_HI_W = CNT_W - BYTE_W;

  logic [DESC_KEPT-1:0]             cap;
  logic [DESC_KEPT-1:0][BYTE_W-1:0] desc;
  logic                             ptr_load, ptr_step, at_limit, use_buf, tx_cap;
  logic [1:0]                       tbl_off;
  bdm_wsel_e                        wsel;
  logic [IDX_W-1:0]                 idx_q;
  logic [ADDR_W-1:0]                tbl_base, buf_addr;
  logic [CNT_W-1:0]                 limit, cnt;
  logic [BYTE_W-1:0]                tx_data_q, tx_data_d;

  assign limit = {desc[OFF_STATUS][CNT_HI_W-1:0], desc[OFF_CNTLO]};

  bdm_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk, .rst_n,
    .start_i, .idx_i(start_idx_i), .dir_i(start_dir_i),
    .rx_valid_i, .rx_last_i, .tx_ready_i,
    .at_limit_i(at_limit), .limit_zero_i(limit == '0),
    .busy_o, .done_o, .idx_o(idx_q), .ovf_o(done_ovf_o),
    .cap_o(cap), .ptr_load_o(ptr_load), .ptr_step_o(ptr_step),
    .ram_req_o, .ram_we_o, .use_buf_o(use_buf), .tbl_off_o(tbl_off),
    .wsel_o(wsel), .rx_ready_o, .tx_cap_o(tx_cap),
    .tx_valid_o, .tx_last_o
  );

  bdm_desc_regs #(.BYTE_W(BYTE_W), .NREG(DESC_KEPT)) u_desc (
    .clk, .rst_n, .cap_i(cap), .byte_i(ram_rdata_i), .regs_o(desc)
  );

  bdm_ptr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ptr (
    .clk, .rst_n,
    .load_i(ptr_load),
    .base_i({ram_rdata_i, desc[OFF_ADRLO]}),
    .limit_i(limit),
    .freeze_i(desc[OFF_STATUS][STAT_FREEZE_BIT]),
    .step_i(ptr_step),
    .addr_o(buf_addr), .cnt_o(cnt), .at_limit_o(at_limit)
  );

  assign tbl_base   = TABLE_BASE + ADDR_W'({idx_q, 2'b00});
  assign ram_addr_o = use_buf ? buf_addr : (tbl_base + ADDR_W'(tbl_off));

  always_comb begin
    unique case (wsel)
      WSEL_CNTLO:  ram_wdata_o = cnt[BYTE_W-1:0];
      WSEL_STATUS: ram_wdata_o = {desc[OFF_STATUS][BYTE_W-1:CNT_HI_W], cnt[CNT_W-1:BYTE_W]};
      default:     ram_wdata_o = rx_data_i;
    endcase
  end

  always_comb begin
    tx_data_d = tx_data_q;
    if (tx_cap) tx_data_d = ram_rdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_data_q <= '0;
    else        tx_data_q <= tx_data_d;
  end

  assign tx_data_o    = tx_data_q;
  assign done_count_o = cnt;

  // R3: a waiting transmit byte is held
  a_r3_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

  // R7: descriptor writes touch only the status and count-low bytes
  a_r7_wb_offsets: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we_o && !use_buf) |-> (ram_addr_o == tbl_base || ram_addr_o == tbl_base + 1'b1));
endmodule

// File: tb/bdesc_mover_tb.sv
module bdesc_mover_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i = 1'b0;
  logic [5:0] start_idx_i = '0;
  logic       start_dir_i = 1'b0;
  logic       busy_o, done_o, done_ovf_o;
  logic [9:0] done_count_o;
  logic       ram_req_o, ram_we_o;
  logic [15:0] ram_addr_o;
  logic [7:0] ram_wdata_o;
  logic [7:0] ram_rdata_i = '0;
  logic       rx_valid_i = 1'b0, rx_last_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic       rx_ready_o, tx_valid_o, tx_last_o;
  logic [7:0] tx_data_o;
  logic       tx_ready_i = 1'b0;

  int checks = 0, fails = 0, cyc = 0;
  int done_pulses = 0, ram_err = 0, tx_n = 0;
  bit tx_stall = 1'b0;
  logic [7:0] mem [0:4095];
  logic [7:0] tx_buf [0:1023];
  bit         tx_lst [0:1023];

  always #10 clk = ~clk;

  bdesc_mover u_dut (.*);

  always @(posedge clk) begin
    if (ram_req_o) begin
      if (ram_addr_o[15:12] != 4'h0) ram_err++;
      if (ram_we_o) mem[ram_addr_o[11:0]] <= ram_wdata_o;
      else          ram_rdata_i <= mem[ram_addr_o[11:0]];
    end
    if (ram_we_o && !ram_req_o) ram_err++;
    if (ram_req_o && !busy_o) ram_err++;
  end

  always @(negedge clk) begin
    if (done_o) done_pulses++;
    tx_ready_i = tx_stall ? (cyc % 3 != 1) : 1'b1;
    if (tx_valid_o && tx_ready_i && tx_n < 1024) begin
      tx_buf[tx_n] = tx_data_o;
      tx_lst[tx_n] = tx_last_o;
      tx_n++;
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual %0d cycles expected <150000", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] tx_pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  function automatic logic [7:0] rx_pat(input int i, input int idx);
    return 8'((i * 13 + idx + 5) & 255);
  endfunction

  task automatic drive_rx(input int nrx, input int idx, input bit gaps);
    for (int i = 0; i < nrx; i++) begin
      if (gaps && (i % 3 == 2)) begin
        rx_valid_i = 1'b0;
        @(negedge clk);
      end
      rx_valid_i = 1'b1;
      rx_data_i  = rx_pat(i, idx);
      rx_last_i  = (i == nrx - 1);
      for (int t = 0; t < 5000 && !rx_ready_o; t++) @(negedge clk);
      @(negedge clk);
    end
    rx_valid_i = 1'b0;
    rx_last_i  = 1'b0;
  endtask

  task automatic run_case(input int idx, input bit dir, input int base, input int lim,
                          input bit frz, input int nrx, input bit stall, input bit extra);
    int tbl, tbl2, exp_cnt, bad, pulses0, t;
    logic [7:0] stat;
    bit exp_ovf;
    tbl  = 'h400 + 4 * idx;
    tbl2 = 'h400 + 4 * ((idx + 1) % 64);
    stat = {3'(idx), frz, 2'b10, 2'(lim >> 8)};
    mem[tbl] = stat; mem[tbl+1] = 8'(lim); mem[tbl+2] = 8'(base); mem[tbl+3] = 8'(base >> 8);
    if (extra) for (int k = 0; k < 4; k++) mem[tbl2+k] = 8'(8'h5A + k);
    for (int i = 0; i < lim + 4; i++) mem[(base + i) & 12'hFFF] = dir ? tx_pat(base + i) : 8'hEE;
    tx_n = 0;
    tx_stall = stall;
    pulses0 = done_pulses;
    start_i = 1'b1; start_idx_i = 6'(idx); start_dir_i = dir;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o === 1'b1, "R8 busy after start", busy_o, 1);
    fork
      begin
        if (!dir) drive_rx(nrx, idx, stall);
      end
      begin
        if (extra) begin
          start_i = 1'b1; start_idx_i = 6'((idx + 1) % 64); start_dir_i = ~dir;
          @(negedge clk);
          start_i = 1'b0;
        end
        t = 0;
        while (done_o !== 1'b1 && t < 20000) begin @(negedge clk); t++; end
      end
    join
    exp_cnt = dir ? lim : (nrx < lim ? nrx : lim);
    exp_ovf = !dir && (nrx > lim);
    chk(done_o === 1'b1, "R8 done seen", done_o, 1);
    chk(busy_o === 1'b1, "R8 busy during done", busy_o, 1);
    chk(done_count_o == 10'(exp_cnt), dir ? "R3 tx count" : "R4 rx count", done_count_o, exp_cnt);
    chk(done_ovf_o == exp_ovf, "R5 overflow flag", done_ovf_o, exp_ovf);
    @(negedge clk);
    chk(busy_o === 1'b0 && done_o === 1'b0, "R8 idle after done", {busy_o, done_o}, 0);
    repeat (4) @(negedge clk);
    chk(done_pulses == pulses0 + 1, "R9 exactly one done pulse", done_pulses - pulses0, 1);
    if (dir) begin
      bad = 0;
      for (int i = 0; i < tx_n && i < lim; i++) begin
        if (tx_buf[i] != tx_pat(base + (frz ? 0 : i))) bad++;
        if (tx_lst[i] != (i == lim - 1)) bad++;
      end
      chk(tx_n == lim, lim == 0 ? "R11 zero-count tx bytes" : "R3 tx byte count", tx_n, lim);
      chk(bad == 0, frz ? "R6 frozen tx data/last" : "R2 R3 tx data/last", bad, 0);
    end else begin
      bad = 0;
      if (frz) begin
        if (exp_cnt > 0 && mem[base & 12'hFFF] != rx_pat(exp_cnt - 1, idx)) bad++;
        if (mem[(base + 1) & 12'hFFF] != 8'hEE) bad++;
      end else begin
        for (int i = 0; i < exp_cnt; i++)
          if (mem[(base + i) & 12'hFFF] != rx_pat(i, idx)) bad++;
      end
      chk(bad == 0, frz ? "R6 frozen rx writes" : "R4 rx buffer writes", bad, 0);
      chk(mem[(base + (frz ? 1 : exp_cnt)) & 12'hFFF] == 8'hEE, "R5 nothing past limit",
          mem[(base + (frz ? 1 : exp_cnt)) & 12'hFFF], 8'hEE);
    end
    chk(mem[tbl+1] == 8'(exp_cnt), "R7 count low writeback", mem[tbl+1], 8'(exp_cnt));
    chk(mem[tbl] == {stat[7:2], 2'(exp_cnt >> 8)}, "R7 status writeback", mem[tbl],
        {stat[7:2], 2'(exp_cnt >> 8)});
    chk(mem[tbl+2] == 8'(base) && mem[tbl+3] == 8'(base >> 8), "R7 address bytes kept",
        {mem[tbl+3], mem[tbl+2]}, base);
    if (extra) begin
      bad = 0;
      for (int k = 0; k < 4; k++) if (mem[tbl2+k] != 8'(8'h5A + k)) bad++;
      chk(bad == 0, "R9 other descriptor untouched", bad, 0);
    end
  endtask

  initial begin
    int idxs [4] = '{0, 1, 37, 63};
    rst_n = 1'b0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(busy_o === 1'b0 && done_o === 1'b0 && ram_req_o === 1'b0 && ram_we_o === 1'b0,
        "R1 reset outputs", {busy_o, done_o, ram_req_o, ram_we_o}, 0);
    chk(rx_ready_o === 1'b0 && tx_valid_o === 1'b0, "R1 reset streams", {rx_ready_o, tx_valid_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    foreach (idxs[j]) begin
      for (int f = 0; f < 2; f++) begin
        for (int lim = 0; lim < 4; lim++) begin
          run_case(idxs[j], 1'b1, 'h500 + 16 * idxs[j], lim, f[0], 0, lim[0], lim == 2);
          for (int n = 1; n <= lim + 2; n++)
            run_case(idxs[j], 1'b0, 'h500 + 16 * idxs[j], lim, f[0], n, n[0], n == 1);
        end
      end
    end
    run_case(0, 1'b1, 'h500, 'h40, 1'b0, 0, 1'b1, 1'b0);
    run_case(3, 1'b0, 'h500, 'h40, 1'b0, 'h40, 1'b0, 1'b0);
    run_case(9, 1'b1, 'h600, 'h102, 1'b0, 0, 1'b0, 1'b0);
    run_case(9, 1'b0, 'h600, 'h101, 1'b0, 'h103, 1'b0, 1'b1);
    chk(ram_err == 0, "R10 RAM access rules", ram_err, 0);
    finish_run();
  end
endmodule